// File: doc/BRIEF.md
# Latched Interrupt Status with Write-One-Clear

This block gathers eight live condition flags from a serial peripheral and turns them into two level interrupt lines for a host. Each flag has an enable bit. When an enabled flag makes a 0-to-1 transition, the matching bit of a latched status register sets. The bit stays set until the host clears it. The latched bits are grouped by nibble. Line 0 carries bits 3..0, which are the transmitter sources: tx full (bit 0), tx empty (bit 1), tx below low mark (bit 2) and tx shifter empty (bit 3). Line 1 carries bits 7..4, which are the receiver sources: rx timeout (bit 4), rx not empty (bit 5), rx above high mark (bit 6) and rx full (bit 7).

A small byte-wide register port gives access to the enable register and to the latched status. A write of ones to the status address does not change the status bits directly. The written byte goes into a hidden clear register. A set clear bit forces its status bit low. The clear bit then drops by itself on the first clock edge at which it sees that status bit already low. Each source bit is a four-state machine, with the state encoded as {clear, status}:
- IDLE (00)
- HELD (01)
- ARMED (11): the clear is loaded and the status is still set.
- DRAIN (10): the status is low and the clear is waiting to retire.

The transitions are:
- any state → HELD on a set event. The set event wins over a pending clear and drops it.
- IDLE → DRAIN on a clear write.
- HELD → ARMED on a clear write.
- ARMED → DRAIN unconditionally.
- DRAIN → IDLE when no new clear write arrives.

The bus port is a two-state machine, BUS_IDLE → BUS_ACK on an accepted request, then BUS_ACK → BUS_IDLE.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After reset the enable register and the latched status read as 0x00, and both interrupt lines are low.
- R2: A request held high in an idle cycle is accepted at the next clock edge. `ack_o` is high for exactly the one cycle after that edge. Address 0 reads and writes the enable register, with bit n enabling source n.
- R3: When enable bit n is high and live flag n goes from 0 to 1, status bit n reads as 1 from the clock edge that first samples the flag high. A read of address 1 returns the status byte, bit n for source n.
- R4: A flag that rises while its enable bit is low latches nothing. Setting the enable bit later, while the flag stays high, also latches nothing.
- R5: A latched bit stays set after its live flag falls.
- R6: A write to address 1 clears every status bit whose data bit is 1. The status bit is still high in the cycle after the write is accepted and low one cycle later. Data bits of 0 leave their status bits unchanged.
- R7: A set event on bit n while its clear is pending keeps bit n set. The pending clear is discarded.
- R8: A flag that is held high across a clear does not set its bit again.
- R9: `irq_o[0]` is the OR of status bits 3..0 and `irq_o[1]` is the OR of status bits 7..4.
- R10: Addresses 2 and 3 read as 0x00, and writes to them change neither the enable register nor the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| live_i | input | 8 | Live condition flags, bit n is source n |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register address: 0 enable, 1 status/clear |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid while `ack_o` is high |
| ack_o | output | 1 | Access acknowledge, one cycle |
| irq_o | output | 2 | Interrupt lines: [0] transmitter group, [1] receiver group |

## Verification
The hardest situation to reach from the ports is a set event that lands in the single cycle in which a clear is pending (state ARMED). The stimulus first lowers a latched flag, then issues the clear write. It raises the flag again at the falling edge right after the write's accept edge, so that the next rising edge sees both the pending clear and the new edge. A second hard case is a level flag that stays high through a clear. It is held for several cycles after the clear, and both the status read and the interrupt lines must stay low.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

    // Per-source state, encoded as {clear_pending, status}
    typedef enum logic [1:0] {
        BIT_IDLE  = 2'b00,
        BIT_HELD  = 2'b01,
        BIT_DRAIN = 2'b10,
        BIT_ARMED = 2'b11
    } bit_state_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_ACK  = 1'b1
    } bus_state_e;

    localparam int unsigned ADDR_ENABLE = 0;
    localparam int unsigned ADDR_STATUS = 1;

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] live_i,
    output logic [WIDTH-1:0] rise_o
);

    logic [WIDTH-1:0] live_q;

    // Sampled during reset too, so a flag already high at release is no edge
    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= live_i;
        end else begin
            live_q <= live_i;
        end
    end

    always_comb begin
        rise_o = live_i & ~live_q;
    end

endmodule

// File: rtl/irq_bit_cell.sv
module irq_bit_cell
    import irq_latch_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_ev_i,
    input  logic clr_wr_i,
    output logic stat_o,
    output logic clr_o
);

    bit_state_e state_q;
    bit_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BIT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (set_ev_i) begin
            state_d = BIT_HELD;              // set wins, pending clear dropped
        end else begin
            unique case (state_q)
                BIT_IDLE:  state_d = clr_wr_i ? BIT_DRAIN : BIT_IDLE;
                BIT_HELD:  state_d = clr_wr_i ? BIT_ARMED : BIT_HELD;
                BIT_ARMED: state_d = BIT_DRAIN;
                BIT_DRAIN: state_d = clr_wr_i ? BIT_DRAIN : BIT_IDLE;
                default:   state_d = BIT_IDLE;
            endcase
        end
    end

    always_comb begin
        stat_o = 1'b0;
        clr_o  = 1'b0;
        unique case (state_q)
            BIT_IDLE:  begin stat_o = 1'b0; clr_o = 1'b0; end
            BIT_HELD:  begin stat_o = 1'b1; clr_o = 1'b0; end
            BIT_ARMED: begin stat_o = 1'b1; clr_o = 1'b1; end
            BIT_DRAIN: begin stat_o = 1'b0; clr_o = 1'b1; end
            default:   begin stat_o = 1'b0; clr_o = 1'b0; end
        endcase
    end

endmodule

// File: rtl/irq_group_or.sv
module irq_group_or #(
    parameter int unsigned N_SRC   = 8,
    parameter int unsigned GROUP_W = 4,
    localparam int unsigned N_LINES = N_SRC / GROUP_W
) (
    input  logic [N_SRC-1:0]   stat_i,
    output logic [N_LINES-1:0] irq_o
);

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        assign irq_o[g] = |stat_i[g*GROUP_W +: GROUP_W];
    end

endmodule

// File: rtl/irq_bus_port.sv
module irq_bus_port
    import irq_latch_pkg::*;
#(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] stat_i,
    output logic [DATA_W-1:0] en_o,
    output logic [DATA_W-1:0] clr_wr_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              ack_o
);

    localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(ADDR_ENABLE);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(ADDR_STATUS);

    bus_state_e        state_q;
    bus_state_e        state_d;
    logic              accept;
    logic [DATA_W-1:0] en_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        accept  = (state_q == BUS_IDLE) && req_i;
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: state_d = accept ? BUS_ACK : BUS_IDLE;
            BUS_ACK:  state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        if (addr_i == A_EN) begin
            rd_mux = en_q;
        end else if (addr_i == A_STS) begin
            rd_mux = stat_i;
        end else begin
            rd_mux = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            rdata_q <= '0;
        end else if (accept) begin
            if (we_i && (addr_i == A_EN)) begin
                en_q <= wdata_i;
            end
            rdata_q <= we_i ? '0 : rd_mux;
        end
    end

    always_comb begin
        clr_wr_o = (accept && we_i && (addr_i == A_STS)) ? wdata_i : '0;
        en_o     = en_q;
        rdata_o  = rdata_q;
        ack_o    = (state_q == BUS_ACK);
    end

endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl #(
    parameter int unsigned N_SRC   = 8,
    parameter int unsigned GROUP_W = 4,
    parameter int unsigned ADDR_W  = 2,
    localparam int unsigned N_LINES = N_SRC / GROUP_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_SRC-1:0]   live_i,
    input  logic               req_i,
    input  logic               we_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [N_SRC-1:0]   wdata_i,
    output logic [N_SRC-1:0]   rdata_o,
    output logic               ack_o,
    output logic [N_LINES-1:0] irq_o
);

    logic [N_SRC-1:0] rise;
    logic [N_SRC-1:0] en_q;
    logic [N_SRC-1:0] clr_wr;
    logic [N_SRC-1:0] stat_q;
    logic [N_SRC-1:0] clr_q;
    logic [N_SRC-1:0] set_ev;

    irq_edge_detect #(.WIDTH(N_SRC)) edge_i (
        .clk    (clk),
        .rst    (rst),
        .live_i (live_i),
        .rise_o (rise)
    );

    irq_bus_port #(.ADDR_W(ADDR_W), .DATA_W(N_SRC)) bus_i (
        .clk      (clk),
        .rst      (rst),
        .req_i    (req_i),
        .we_i     (we_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .stat_i   (stat_q),
        .en_o     (en_q),
        .clr_wr_o (clr_wr),
        .rdata_o  (rdata_o),
        .ack_o    (ack_o)
    );

    assign set_ev = rise & en_q;

    for (genvar n = 0; n < N_SRC; n++) begin : g_src
        irq_bit_cell cell_i (
            .clk      (clk),
            .rst      (rst),
            .set_ev_i (set_ev[n]),
            .clr_wr_i (clr_wr[n]),
            .stat_o   (stat_q[n]),
            .clr_o    (clr_q[n])
        );
    end

    irq_group_or #(.N_SRC(N_SRC), .GROUP_W(GROUP_W)) or_i (
        .stat_i (stat_q),
        .irq_o  (irq_o)
    );

endmodule

// File: rtl/irq_latch_chk.sv
module irq_latch_chk #(
    parameter int unsigned N_SRC   = 8,
    parameter int unsigned GROUP_W = 4,
    parameter int unsigned N_LINES = 2
) (
    input logic               clk,
    input logic               rst,
    input logic [N_SRC-1:0]   live_i,
    input logic [N_SRC-1:0]   en_q,
    input logic [N_SRC-1:0]   stat_q,
    input logic [N_SRC-1:0]   clr_q,
    input logic               ack_o,
    input logic [N_LINES-1:0] irq_o
);

    logic [N_SRC-1:0] live_prev;
    logic [N_SRC-1:0] set_seen;

    always_ff @(posedge clk) begin
        live_prev <= live_i;
    end

    assign set_seen = live_i & ~live_prev & en_q;

    p_ack_single_r2: assert property (@(posedge clk) disable iff (rst)
        ack_o |=> !ack_o);

    p_set_lands_r3: assert property (@(posedge clk) disable iff (rst)
        (|set_seen) |=> ((stat_q & $past(set_seen)) == $past(set_seen)));

    p_no_stray_set_r4: assert property (@(posedge clk) disable iff (rst)
        ((stat_q & ~$past(stat_q) & ~$past(set_seen)) == '0));

    p_clear_forces_r6: assert property (@(posedge clk) disable iff (rst)
        ((stat_q & $past(clr_q & ~set_seen)) == '0));

    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (|(set_seen & clr_q)) |=> ((clr_q & $past(set_seen & clr_q)) == '0));

    for (genvar g = 0; g < N_LINES; g++) begin : g_line_chk
        p_irq_rise_r9: assert property (@(posedge clk) disable iff (rst)
            $rose(irq_o[g]) |-> $past(|set_seen[g*GROUP_W +: GROUP_W]));
        p_irq_fall_r9: assert property (@(posedge clk) disable iff (rst)
            $fell(irq_o[g]) |-> $past(|clr_q[g*GROUP_W +: GROUP_W]));
    end

endmodule

bind irq_latch_ctrl irq_latch_chk #(
    .N_SRC   (N_SRC),
    .GROUP_W (GROUP_W),
    .N_LINES (N_LINES)
) chk_i (
    .clk    (clk),
    .rst    (rst),
    .live_i (live_i),
    .en_q   (en_q),
    .stat_q (stat_q),
    .clr_q  (clr_q),
    .ack_o  (ack_o),
    .irq_o  (irq_o)
);

// File: tb/irq_latch_ctrl_tb_top.sv
module irq_latch_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] live;
    logic       req;
    logic       we;
    logic [1:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       ack;
    logic [1:0] irq;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;
    bit  cur_is_read = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_latch_ctrl dut_i (
        .clk     (clk),
        .rst     (rst),
        .live_i  (live),
        .req_i   (req),
        .we_i    (we),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .ack_o   (ack),
        .irq_o   (irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cur_is_read = 1'b0;
        req = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1;
        req = 1'b0; we = 1'b0;
        @(negedge clk);
    endtask

    // Driver: pushes the expected read value into the scoreboard
    task automatic bus_rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        cur_is_read = 1'b1;
        req = 1'b1; we = 1'b0; addr = a;
        @(posedge clk);
        #1;
        req = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops and compares each read result
    always @(negedge clk) begin
        if (ack && cur_is_read) begin
            if (exp_q.size() == 0) begin
                chk("scoreboard underflow", rdata, 8'hxx);
            end else begin
                chk(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; live = '0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 irq after reset", {6'b0, irq}, 8'h00);
        bus_rd(2'd0, 8'h00, "R1 enable after reset");
        bus_rd(2'd1, 8'h00, "R1 status after reset");

        // R2: enable register access and one-cycle ack
        bus_wr(2'd0, 8'h5A);
        chk("R2 ack held one cycle", {7'b0, ack}, 8'h01);
        @(posedge clk); #1;
        chk("R2 ack drops", {7'b0, ack}, 8'h00);
        bus_rd(2'd0, 8'h5A, "R2 enable readback");
        bus_wr(2'd0, 8'h43);

        // R3, R9: enabled rising flag latches, line 0 rises
        @(negedge clk); live[0] = 1'b1;
        @(negedge clk);
        chk("R3 R9 irq after set bit0", {6'b0, irq}, 8'h01);
        bus_rd(2'd1, 8'h01, "R3 status bit0 set");

        // R5: stays set after flag falls
        live[0] = 1'b0;
        idle(2);
        bus_rd(2'd1, 8'h01, "R5 held after flag low");

        // R9: receiver group line
        live[6] = 1'b1;
        @(negedge clk);
        chk("R9 both lines", {6'b0, irq}, 8'h03);
        bus_rd(2'd1, 8'h41, "R9 status bits 0 and 6");

        // R6: clear timing and zero bits untouched
        bus_wr(2'd1, 8'h40);
        chk("R6 still high one cycle after accept", {6'b0, irq}, 8'h03);
        @(negedge clk);
        chk("R6 low two cycles after accept", {6'b0, irq}, 8'h01);
        bus_rd(2'd1, 8'h01, "R6 bit6 cleared");
        live[6] = 1'b0;
        bus_wr(2'd1, 8'hFE);
        bus_rd(2'd1, 8'h01, "R6 zero data bit keeps bit0");

        // R7: set event while clear pending (ARMED)
        bus_wr(2'd1, 8'h01);
        live[0] = 1'b1;
        @(negedge clk);
        chk("R7 set wins irq", {6'b0, irq}, 8'h01);
        idle(3);
        bus_rd(2'd1, 8'h01, "R7 set wins status");
        live[0] = 1'b0;
        bus_wr(2'd1, 8'h01);
        idle(2);
        bus_rd(2'd1, 8'h00, "R6 bit0 cleared");

        // R8: level held across clear
        live[1] = 1'b1;
        @(negedge clk);
        bus_rd(2'd1, 8'h02, "R8 bit1 latched");
        bus_wr(2'd1, 8'h02);
        idle(4);
        chk("R8 no relatch irq", {6'b0, irq}, 8'h00);
        bus_rd(2'd1, 8'h00, "R8 no relatch status");

        // R4: disabled source, then enabled while high
        live[5] = 1'b1;
        idle(2);
        bus_rd(2'd1, 8'h00, "R4 disabled no latch");
        bus_wr(2'd0, 8'h63);
        idle(3);
        chk("R4 enable while high irq", {6'b0, irq}, 8'h00);
        bus_rd(2'd1, 8'h00, "R4 enable while high status");
        live[5] = 1'b0;
        idle(1);
        live[5] = 1'b1;
        @(negedge clk);
        chk("R3 R9 bit5 line1", {6'b0, irq}, 8'h02);
        bus_rd(2'd1, 8'h20, "R3 bit5 latched");
        bus_wr(2'd1, 8'h20);
        idle(2);

        // R10: unmapped addresses
        bus_wr(2'd3, 8'hFF);
        bus_wr(2'd2, 8'hFF);
        bus_rd(2'd0, 8'h63, "R10 enable unchanged");
        bus_rd(2'd2, 8'h00, "R10 addr2 reads zero");
        bus_rd(2'd3, 8'h00, "R10 addr3 reads zero");
        bus_rd(2'd1, 8'h00, "R10 status unchanged");

        idle(2);
        chk("scoreboard drained", 8'(exp_q.size()), 8'h00);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule